// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is the second-operand shifter of a 32-bit integer datapath. Each cycle it can accept one operand, a 2-bit shift kind and an amount, and one clock later it returns the shifted word together with the shifter carry-out. The incoming carry flag is an input because some encodings use it. The block does not do the ALU add or subtract, does not write flags back and does not decode instructions.

A mode select chooses where the amount comes from. The first source is a 5-bit field taken from the instruction word (immediate form). The second is the low 8 bits of a register value (register form). The two forms give different meanings to a zero amount and to amounts of 32 or more. The immediate form uses its zero code to mean "shift by 32" for the right shifts and "rotate right by one through the carry" for the rotate. The register form treats zero as "no shift". It also saturates logical shifts to zero and arithmetic shifts to a sign fill. The block resolves all of these cases in hardware and produces the exact carry bit for each one.

Top module: `bshift_unit`

## Requirements
- R1: The shift kind encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right (sign fill) and 3 = rotate right. For an amount n in 1..31 in either form, the result is the input shifted or rotated by n.
- R2: For an amount n in 1..31, the carry-out is input bit n-1 for logical right, arithmetic right and rotate right, and input bit 32-n for logical left.
- R3: Immediate form (in_use_reg = 0), logical left with amount 0: the result equals the input and the carry-out equals in_carry.
- R4: Immediate form, logical right with amount 0 acts as a shift by 32: the result is 0 and the carry-out is input bit 31.
- R5: Immediate form, arithmetic right with amount 0 acts as a shift by 32: every result bit equals input bit 31, and the carry-out is input bit 31.
- R6: Immediate form, rotate right with amount 0 rotates by one through the carry: the result is {in_carry, input[31:1]} and the carry-out is input bit 0.
- R7: Register form (in_use_reg = 1), amount 0: for every kind the result equals the input and the carry-out equals in_carry.
- R8: Register form, logical left or logical right with an amount of 32 or more gives a zero result. At exactly 32 the carry-out is input bit 0 for left and input bit 31 for right. Above 32 the carry-out is 0.
- R9: Register form, arithmetic right with an amount of 32 or more fills the result with input bit 31, and the carry-out is input bit 31.
- R10: Register form, rotate right uses the amount modulo 32. If the amount is nonzero and its low five bits are zero, the result equals the input and the carry-out is input bit 31.
- R11: out_valid equals in_valid of the previous clock. out_data and out_carry belong to that accepted operand. A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Value to shift |
| in_kind | input | 2 | Shift kind (0 left, 1 right, 2 arithmetic right, 3 rotate) |
| in_use_reg | input | 1 | 0 = immediate amount, 1 = register amount |
| in_imm_amt | input | 5 | Immediate-form amount |
| in_reg_amt | input | 8 | Register-form amount (low byte of the register) |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Shifted result |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its defaults: DATA_W = 32 and REG_AMT_W = 8. This gives a register amount range of 0..255. That range reaches the exact-32 edge, the beyond-32 saturation for every kind, and rotate amounts such as 64 and 224, whose low five bits are zero. A 32-bit word also puts the RRX bit and the bit-0 and bit-31 carry picks at the boundaries named in the requirements. Random operands, kinds and amounts are weighted toward 0, 32, multiples of 32 and small values, and are mixed with directed cases for each special encoding.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Shift kind carried on in_kind
    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    // How the amount decoder classifies a request
    typedef enum logic [2:0] {
        AC_PASS   = 3'd0,   // no movement, carry flag passes
        AC_NORM   = 3'd1,   // amount 1..W-1 through the barrel
        AC_RRX    = 3'd2,   // rotate by one through the carry
        AC_EDGE   = 3'd3,   // shift by exactly W
        AC_BEYOND = 3'd4    // shift by more than W
    } amt_class_e;

    // Output of the final select stage
    typedef struct packed {
        logic        carry;
        logic [31:0] data;
    } shift_res_t;

    function automatic logic is_right_logic(shift_kind_e k);
        return (k == SK_LSR);
    endfunction

endpackage

// File: rtl/bshift_amt_norm.sv
module bshift_amt_norm
    import bshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int STAGES   = $clog2(DATA_W)
) (
    input  shift_kind_e             kind,
    input  logic                    use_reg,
    input  logic [STAGES-1:0]       imm_amt,
    input  logic [REG_AMT_W-1:0]    reg_amt,
    output amt_class_e              cls,
    output logic [STAGES-1:0]       amt
);

    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    always_comb begin
        cls = AC_NORM;
        amt = imm_amt;
        if (!use_reg) begin
            if (imm_amt == '0) begin
                unique case (kind)
                    SK_LSL:  cls = AC_PASS;
                    SK_ROR:  cls = AC_RRX;
                    default: cls = AC_EDGE;
                endcase
            end
        end else begin
            amt = reg_amt[STAGES-1:0];
            if (reg_amt == '0) begin
                cls = AC_PASS;
            end else if (kind == SK_ROR) begin
                if (reg_amt[STAGES-1:0] == '0) cls = AC_EDGE;
            end else if (reg_amt == FULL_AMT) begin
                cls = AC_EDGE;
            end else if (reg_amt > FULL_AMT) begin
                cls = AC_BEYOND;
            end
        end
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int DATA_W  = 32,
    localparam int STAGES = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  data,
    input  shift_kind_e        kind,
    input  logic [STAGES-1:0]  amt,
    output logic [DATA_W-1:0]  res,
    output logic               carry
);

    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] stage [0:STAGES];
    logic [DATA_W-1:0] rev_out;
    logic              fill_bit;
    logic              is_rot;
    logic              is_left;
    logic [STAGES-1:0] pick;

    // Left shifts run through the right-shift network on reversed bits
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = data[DATA_W-1-i];
        assign rev_out[i] = stage[STAGES][DATA_W-1-i];
    end

    assign is_left  = (kind == SK_LSL);
    assign is_rot   = (kind == SK_ROR);
    assign fill_bit = (kind == SK_ASR) & data[DATA_W-1];
    assign src      = is_left ? rev_in : data;
    assign stage[0] = src;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int SH = 1 << k;
        logic [DATA_W-1:0] rot_k;
        logic [DATA_W-1:0] shf_k;
        assign rot_k = {stage[k][SH-1:0], stage[k][DATA_W-1:SH]};
        assign shf_k = {{SH{fill_bit}}, stage[k][DATA_W-1:SH]};
        assign stage[k+1] = !amt[k] ? stage[k] : (is_rot ? rot_k : shf_k);
    end

    assign res = is_left ? rev_out : stage[STAGES];

    // Last bit shifted out: src[n-1] covers both directions (left via reversal)
    assign pick  = amt - STAGES'(1);
    assign carry = src[pick];

endmodule

// File: rtl/bshift_select.sv
module bshift_select
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  amt_class_e         cls,
    input  shift_kind_e        kind,
    input  logic [DATA_W-1:0]  data,
    input  logic               cin,
    input  logic [DATA_W-1:0]  core_res,
    input  logic               core_carry,
    output logic [DATA_W-1:0]  res,
    output logic               carry
);

    logic msb;
    assign msb = data[DATA_W-1];

    always_comb begin
        res   = core_res;
        carry = core_carry;
        unique case (cls)
            AC_PASS: begin
                res   = data;
                carry = cin;
            end
            AC_RRX: begin
                res   = {cin, data[DATA_W-1:1]};
                carry = data[0];
            end
            AC_EDGE: begin
                unique case (kind)
                    SK_LSL: begin res = '0;             carry = data[0]; end
                    SK_LSR: begin res = '0;             carry = msb;     end
                    SK_ASR: begin res = {DATA_W{msb}};  carry = msb;     end
                    SK_ROR: begin res = data;           carry = msb;     end
                endcase
            end
            AC_BEYOND: begin
                if (kind == SK_ASR) begin
                    res   = {DATA_W{msb}};
                    carry = msb;
                end else begin
                    res   = '0;
                    carry = 1'b0;
                end
            end
            default: begin
                res   = core_res;
                carry = core_carry;
            end
        endcase
    end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int STAGES   = $clog2(DATA_W)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [1:0]            in_kind,
    input  logic                  in_use_reg,
    input  logic [STAGES-1:0]     in_imm_amt,
    input  logic [REG_AMT_W-1:0]  in_reg_amt,
    input  logic                  in_carry,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_carry
);

    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    shift_kind_e        kind;
    amt_class_e         cls;
    logic [STAGES-1:0]  amt;
    logic [DATA_W-1:0]  core_res;
    logic               core_carry;
    logic [DATA_W-1:0]  sel_res;
    logic               sel_carry;

    assign kind = shift_kind_e'(in_kind);

    bshift_amt_norm #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) i_norm (
        .kind    (kind),
        .use_reg (in_use_reg),
        .imm_amt (in_imm_amt),
        .reg_amt (in_reg_amt),
        .cls     (cls),
        .amt     (amt)
    );

    bshift_core #(.DATA_W(DATA_W)) i_core (
        .data  (in_data),
        .kind  (kind),
        .amt   (amt),
        .res   (core_res),
        .carry (core_carry)
    );

    bshift_select #(.DATA_W(DATA_W)) i_sel (
        .cls        (cls),
        .kind       (kind),
        .data       (in_data),
        .cin        (in_carry),
        .core_res   (core_res),
        .core_carry (core_carry),
        .res        (sel_res),
        .carry      (sel_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            out_data  <= sel_res;
            out_carry <= sel_carry;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);                                          // R11
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                        // R11
    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && in_reg_amt == '0)
        |=> (out_data == $past(in_data) && out_carry == $past(in_carry))); // R7
    AST_RRX_FORM: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_use_reg && in_kind == 2'd3 && in_imm_amt == '0)
        |=> (out_data == {$past(in_carry), $past(in_data[DATA_W-1:1])}
             && out_carry == $past(in_data[0])));                         // R6
    AST_LOGIC_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && !in_kind[1] && in_reg_amt > FULL_AMT)
        |=> (out_data == '0 && !out_carry));                              // R8
    AST_ASR_FILL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && in_kind == 2'd2 && in_reg_amt >= FULL_AMT)
        |=> (out_data == {DATA_W{$past(in_data[DATA_W-1])}}
             && out_carry == $past(in_data[DATA_W-1])));                 // R9

endmodule

// File: tb/test_bshift_unit.sv
`timescale 1ns/1ps
module test_bshift_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [1:0]  in_kind = '0;
    logic        in_use_reg = 1'b0;
    logic [4:0]  in_imm_amt = '0;
    logic [7:0]  in_reg_amt = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_carry;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bshift_unit i_bshift_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_kind(in_kind), .in_use_reg(in_use_reg), .in_imm_amt(in_imm_amt),
        .in_reg_amt(in_reg_amt), .in_carry(in_carry), .out_valid(out_valid),
        .out_data(out_data), .out_carry(out_carry)
    );

    // Shift by n in 1..31 (R1, R2)
    function automatic logic [32:0] ref_norm(logic [31:0] d, logic [1:0] k, int n);
        logic [31:0] r;
        logic        c;
        case (k)
            2'd0: begin r = d << n;                     c = d[32-n]; end
            2'd1: begin r = d >> n;                     c = d[n-1];  end
            2'd2: begin r = $unsigned($signed(d) >>> n); c = d[n-1];  end
            default: begin r = (d >> n) | (d << (32-n)); c = d[n-1]; end
        endcase
        return {c, r};
    endfunction

    function automatic logic [32:0] ref_shift(logic [31:0] d, logic [1:0] k,
            logic use_reg, logic [4:0] imm, logic [7:0] ra, logic cin);
        if (!use_reg) begin
            if (imm != 0) return ref_norm(d, k, int'(imm));
            case (k)
                2'd0: return {cin, d};                      // R3
                2'd1: return {d[31], 32'd0};                // R4
                2'd2: return {d[31], {32{d[31]}}};          // R5
                default: return {d[0], cin, d[31:1]};       // R6
            endcase
        end
        if (ra == 0) return {cin, d};                       // R7
        case (k)
            2'd0: begin
                if (ra < 32) return ref_norm(d, k, int'(ra));
                return (ra == 32) ? {d[0], 32'd0} : 33'd0;  // R8
            end
            2'd1: begin
                if (ra < 32) return ref_norm(d, k, int'(ra));
                return (ra == 32) ? {d[31], 32'd0} : 33'd0; // R8
            end
            2'd2: begin
                if (ra < 32) return ref_norm(d, k, int'(ra));
                return {d[31], {32{d[31]}}};                // R9
            end
            default: begin
                if (ra[4:0] == 0) return {d[31], d};        // R10
                return ref_norm(d, k, int'(ra[4:0]));
            end
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(string tag, logic [31:0] d, logic [1:0] k,
            logic use_reg, logic [4:0] imm, logic [7:0] ra, logic cin);
        logic [32:0] exp;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_kind = k; in_use_reg = use_reg;
        in_imm_amt = imm; in_reg_amt = ra; in_carry = cin;
        exp = ref_shift(d, k, use_reg, imm, ra, cin);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check(tag, {31'd0, out_carry, out_data}, {31'd0, exp});
    endtask

    function automatic logic [7:0] pick_reg_amt();
        case ($urandom % 6)
            0: return 8'd0;
            1: return 8'd32;
            2: return 8'(($urandom % 8) * 32);
            3: return 8'(($urandom % 31) + 1);
            4: return 8'(33 + ($urandom % 3));
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd51966);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        check("R11 reset clears valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R11 idle valid low", 64'(out_valid), 64'd0);

        // Directed: immediate form
        run_op("R1 lsl imm 4",  32'h0000_00F1, 2'd0, 1'b0, 5'd4, 8'd0, 1'b0);
        check("R1 lsl value", 64'(out_data), 64'h0000_0F10);
        run_op("R2 lsl imm 1 carry", 32'h8000_0000, 2'd0, 1'b0, 5'd1, 8'd0, 1'b0);
        check("R2 lsl carry bit31", 64'(out_carry), 64'd1);
        run_op("R2 lsr imm 31", 32'h4000_0001, 2'd1, 1'b0, 5'd31, 8'd0, 1'b0);
        run_op("R1 asr imm 8",  32'h8765_4321, 2'd2, 1'b0, 5'd8, 8'd0, 1'b0);
        check("R1 asr value", 64'(out_data), 64'hFF87_6543);
        run_op("R1 ror imm 4",  32'h1234_5678, 2'd3, 1'b0, 5'd4, 8'd0, 1'b0);
        check("R1 ror value", 64'(out_data), 64'h8123_4567);
        run_op("R3 lsl imm 0",  32'hDEAD_BEEF, 2'd0, 1'b0, 5'd0, 8'd0, 1'b1);
        run_op("R4 lsr imm 0",  32'h8000_0000, 2'd1, 1'b0, 5'd0, 8'd0, 1'b0);
        check("R4 value", {31'd0, out_carry, out_data}, 64'h1_0000_0000);
        run_op("R5 asr imm 0",  32'h8000_0000, 2'd2, 1'b0, 5'd0, 8'd0, 1'b0);
        check("R5 value", {31'd0, out_carry, out_data}, 64'h1_FFFF_FFFF);
        run_op("R6 rrx",        32'h0000_0003, 2'd3, 1'b0, 5'd0, 8'd0, 1'b1);
        check("R6 value", {31'd0, out_carry, out_data}, 64'h1_8000_0001);

        // Directed: register form
        for (int k = 0; k < 4; k++)
            run_op("R7 reg zero", 32'hA5A5_0F0F, 2'(k), 1'b1, 5'd7, 8'd0, 1'b1);
        run_op("R8 lsl reg 32",  32'h0000_0001, 2'd0, 1'b1, 5'd0, 8'd32, 1'b0);
        check("R8 lsl 32 value", {31'd0, out_carry, out_data}, 64'h1_0000_0000);
        run_op("R8 lsr reg 32",  32'h8000_0000, 2'd1, 1'b1, 5'd0, 8'd32, 1'b0);
        run_op("R8 lsl reg 33",  32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 8'd33, 1'b1);
        run_op("R8 lsr reg 255", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 8'd255, 1'b1);
        run_op("R9 asr reg 32",  32'h8000_0000, 2'd2, 1'b1, 5'd0, 8'd32, 1'b0);
        run_op("R9 asr reg 200", 32'h7FFF_FFFF, 2'd2, 1'b1, 5'd0, 8'd200, 1'b1);
        run_op("R10 ror reg 32", 32'h8000_0001, 2'd3, 1'b1, 5'd0, 8'd32, 1'b0);
        run_op("R10 ror reg 224",32'h1234_5678, 2'd3, 1'b1, 5'd0, 8'd224, 1'b1);
        run_op("R10 ror reg 36", 32'h1234_5678, 2'd3, 1'b1, 5'd0, 8'd36, 1'b0);
        check("R10 mod value", 64'(out_data), 64'h8123_4567);
        @(negedge clk);
        check("R11 valid drops", 64'(out_valid), 64'd0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic use_reg;
            use_reg = 1'($urandom);
            run_op(use_reg ? "R2 random reg" : "R2 random imm",
                   (($urandom % 4) == 0) ? 32'h8000_0001 : 32'($urandom),
                   2'($urandom), use_reg,
                   (($urandom % 4) == 0) ? 5'd0 : 5'($urandom),
                   pick_reg_amt(), 1'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule